// File: doc/BRIEF.md
# Clock-Selectable Serial Shift Register

This block holds an 8-bit data word that a processor can load and read back. On each clock event it shifts one place toward the MSB. The new LSB is taken from a serial input pin. The MSB leaves on a serial output pin through an output latch. A two-bit source select and a one-shot strobe bit pick what clocks the shifter:

- nothing;
- a software strobe written along with the select;
- a pulse from a timer's compare match;
- the rising edge of an external serial clock;
- the falling edge of that external serial clock.

The external clock and the serial input are asynchronous to the system clock. Each passes through a two-flop synchronizer before edges are detected or bits are sampled.

The output pin timing depends on the source. With an internal source (strobe or timer), the output latch is transparent, so the pin follows the MSB as soon as the register changes. With an external source, the latch updates only on the clock edge opposite the sampling edge. This gives the half-period of setup that serial peers expect.

A processor write always beats a shift that lands in the same cycle. A second register, the buffer, takes a copy of the data word whenever a transfer-complete pulse arrives from outside.

Top module: `ssrTop`

## Requirements
- R1: With select 00 and no strobe, neither a timer pulse nor external clock edges change the data word. A control write with select 00 and strobe 1 shifts exactly once.
- R2: A shift moves `dataOut[6:0]` to `dataOut[7:1]` and puts the sampled serial bit into `dataOut[0]`.
- R3: With select 01, each single-cycle `timerMatch` pulse shifts once.
- R4: With select 10, the word shifts on synchronized rising edges of `extClk`. With select 11, it shifts on falling edges. `extClk` and `serIn` each pass through two synchronizer flops first.
- R5: With select 10, `serOut` is reloaded from the MSB only on falling edges of `extClk`. With select 11, it is reloaded only on rising edges. Between such edges `serOut` holds.
- R6: With select 00 or 01, `serOut` equals `dataOut[7]` in every cycle.
- R7: For a software strobe, the shifted-in bit is the synchronized serial input from the cycle before the strobe. A `serIn` change in the strobe cycle itself is not used.
- R8: When `cpuWrEn` and a shift event fall in the same cycle, the data word becomes `cpuWrData` and no shift occurs.
- R9: `ctrlRead` returns {select[1:0], 0}. Bit 0, the strobe position, always reads 0.
- R10: `bufOut` loads the data word on the cycle after `xferDone`, and holds otherwise.
- R11: After reset, `dataOut`, `bufOut`, `serOut` and `ctrlRead` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuWrEn | input | 1 | Load the data word this cycle |
| cpuWrData | input | 8 | Value to load |
| ctrlWrEn | input | 1 | Write the control fields this cycle |
| ctrlSel | input | 2 | Clock source select: 00 none/strobe, 01 timer, 10 ext rising, 11 ext falling |
| ctrlStrobe | input | 1 | Software strobe bit, acted on only when written with select 00 |
| timerMatch | input | 1 | Timer compare-match pulse |
| extClk | input | 1 | External serial clock (asynchronous) |
| serIn | input | 1 | Serial data input (asynchronous) |
| xferDone | input | 1 | Transfer-complete pulse; copies the data word to the buffer |
| dataOut | output | 8 | Current data word |
| bufOut | output | 8 | Buffer copy of the data word |
| ctrlRead | output | 3 | Control readback {select, strobe=0} |
| serOut | output | 1 | Serial data output |

## Verification
Assertions watch every cycle for the following:
- a processor write taking priority over a shift;
- the shape of each shift, with the MSB leaving and the sampled bit entering;
- external shifts happening only on the selected synchronized edge;
- no shift with select 00 unless a control write is in progress;
- the external output latch holding between its update edges;
- the buffer capturing the word after a transfer pulse.

Only the bench scenarios can show the end-to-end behaviour:
- the two-flop delay seen from the pins;
- a strobe using the serial bit from the cycle before, not the one written alongside it;
- the output changing on the edge opposite the sampling edge in both external modes;
- the exact word built up over a sequence of strobes.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // Clock source codes; the value decides which event shifts the word.
  localparam logic [1:0] SRC_SOFT  = 2'b00;
  localparam logic [1:0] SRC_TIMER = 2'b01;
  localparam logic [1:0] SRC_RISE  = 2'b10;
  localparam logic [1:0] SRC_FALL  = 2'b11;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic load;        // processor write of the data word
    logic shift;       // a clock event selected by the source
    logic shiftBit;    // bit entering at the LSB
    logic latchUpd;    // reload the output latch from the MSB
    logic transparent; // internal source: output follows the MSB
    logic capture;     // copy data word into the buffer
  } dpCtl_t;

endpackage

// File: rtl/ssrSync.sv
module ssrSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[s] <= '0;
        end else begin
          if (s == 0) stage[s] <= asyncIn;
          else        stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/ssrControl.sv
module ssrControl
  import ssr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [1:0] ctrlSel,
  input  logic       ctrlStrobe,
  input  logic       cpuWrEn,
  input  logic       timerMatch,
  input  logic       xferDone,
  input  logic       extClkSync,
  input  logic       serInSync,
  output dpCtl_t     ctl,
  output logic [1:0] selOut
);

  logic [1:0] selReg;
  logic [1:0] effSel;
  logic       extPrev;
  logic       inDly;
  logic       riseEv;
  logic       fallEv;
  logic       swStrobe;
  logic       shiftEv;
  logic       updEv;

  // Control register: select kept, strobe acted on only in its write cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= SRC_SOFT;
      extPrev <= 1'b0;
      inDly   <= 1'b0;
    end else begin
      if (ctrlWrEn) selReg <= ctrlSel;
      extPrev <= extClkSync;
      inDly   <= serInSync;
    end
  end

  // The select being written applies in the same cycle as its strobe.
  assign effSel   = ctrlWrEn ? ctrlSel : selReg;
  assign riseEv   = extClkSync & ~extPrev;
  assign fallEv   = ~extClkSync & extPrev;
  assign swStrobe = ctrlWrEn & ctrlStrobe & (ctrlSel == SRC_SOFT);

  always_comb begin
    shiftEv = 1'b0;
    updEv   = 1'b1;
    unique case (effSel)
      SRC_SOFT:  begin shiftEv = swStrobe;   updEv = 1'b1;   end
      SRC_TIMER: begin shiftEv = timerMatch; updEv = 1'b1;   end
      SRC_RISE:  begin shiftEv = riseEv;     updEv = fallEv; end
      SRC_FALL:  begin shiftEv = fallEv;     updEv = riseEv; end
      default:   begin shiftEv = 1'b0;       updEv = 1'b0;   end
    endcase
  end

  always_comb begin
    ctl.load        = cpuWrEn;
    ctl.shift       = shiftEv;
    // Internal sources use the bit from the cycle before; external uses the
    // bit present at the sampling edge.
    ctl.shiftBit    = effSel[1] ? serInSync : inDly;
    ctl.latchUpd    = updEv;
    ctl.transparent = ~effSel[1];
    ctl.capture     = xferDone;
  end

  assign selOut = selReg;

  // R1: with select 00 held and no control write, nothing shifts.
  assert_no_idle_shift_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWrEn && selReg == SRC_SOFT) |-> !ctl.shift);

  // R4: external rising-edge mode shifts only on a synchronized 0->1.
  assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWrEn && selReg == SRC_RISE && ctl.shift) |-> (extClkSync && !$past(extClkSync)));

  // R4: external falling-edge mode shifts only on a synchronized 1->0.
  assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWrEn && selReg == SRC_FALL && ctl.shift) |-> (!extClkSync && $past(extClkSync)));

endmodule

// File: rtl/ssrDatapath.sv
module ssrDatapath
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataWord,
  output logic [DATA_W-1:0] bufWord,
  output logic              serOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] bufReg;
  logic              outLatch;

  // Processor write wins over a shift in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (ctl.load) begin
      dataReg <= wrData;
    end else if (ctl.shift) begin
      dataReg <= {dataReg[MSB-1:0], ctl.shiftBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= 1'b0;
      bufReg   <= '0;
    end else begin
      if (ctl.latchUpd) outLatch <= dataReg[MSB];
      if (ctl.capture)  bufReg   <= dataReg;
    end
  end

  assign serOut   = ctl.transparent ? dataReg[MSB] : outLatch;
  assign dataWord = dataReg;
  assign bufWord  = bufReg;

  // R8: a write cycle leaves exactly the written value.
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (dataReg == $past(wrData)));

  // R2: a shift moves the word up one place and brings in the sampled bit.
  assert_shift_shape_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && !ctl.load) |=> (dataReg == {$past(dataReg[MSB-1:0]), $past(ctl.shiftBit)}));

  // R5: in external modes the output holds unless its update edge occurs.
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.transparent && !ctl.latchUpd) |=> (ctl.transparent || $stable(serOut)));

  // R10: the buffer captures the word present in the transfer cycle.
  assert_buffer_copy_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (bufReg == $past(dataReg)));

endmodule

// File: rtl/ssrTop.sv
module ssrTop
  import ssr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              ctrlWrEn,
  input  logic [1:0]        ctrlSel,
  input  logic              ctrlStrobe,
  input  logic              timerMatch,
  input  logic              extClk,
  input  logic              serIn,
  input  logic              xferDone,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] bufOut,
  output logic [2:0]        ctrlRead,
  output logic              serOut
);

  logic [1:0] syncVec;
  logic [1:0] selNow;
  dpCtl_t     ctl;

  ssrSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({extClk, serIn}),
    .syncOut (syncVec)
  );

  ssrControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlSel    (ctrlSel),
    .ctrlStrobe (ctrlStrobe),
    .cpuWrEn    (cpuWrEn),
    .timerMatch (timerMatch),
    .xferDone   (xferDone),
    .extClkSync (syncVec[1]),
    .serInSync  (syncVec[0]),
    .ctl        (ctl),
    .selOut     (selNow)
  );

  ssrDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (cpuWrData),
    .dataWord (dataOut),
    .bufWord  (bufOut),
    .serOut   (serOut)
  );

  // Strobe position is write-only and returns zero.
  assign ctrlRead = {selNow, 1'b0};

endmodule

// File: tb/sim_ssrTop.sv
module sim_ssrTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWrEn = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic       ctrlWrEn = 1'b0;
  logic [1:0] ctrlSel = '0;
  logic       ctrlStrobe = 1'b0;
  logic       timerMatch = 1'b0;
  logic       extClk = 1'b0;
  logic       serIn = 1'b0;
  logic       xferDone = 1'b0;
  logic [7:0] dataOut;
  logic [7:0] bufOut;
  logic [2:0] ctrlRead;
  logic       serOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ssrTop u0 (.*);

  // Strobe walk: {serial bit, expected word}, starting from 8'hA5.
  localparam logic [8:0] STROBE_VEC [0:7] = '{
    {1'b1, 8'h4B}, {1'b0, 8'h96}, {1'b1, 8'h2D}, {1'b1, 8'h5B},
    {1'b0, 8'hB6}, {1'b0, 8'h6C}, {1'b1, 8'hD9}, {1'b0, 8'hB2}
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [7:0] v);
    cpuWrEn = 1'b1; cpuWrData = v; tick(); cpuWrEn = 1'b0;
  endtask

  task automatic setSel(input logic [1:0] s, input logic stb);
    ctrlWrEn = 1'b1; ctrlSel = s; ctrlStrobe = stb; tick();
    ctrlWrEn = 1'b0; ctrlStrobe = 1'b0;
  endtask

  task automatic timerPulse();
    timerMatch = 1'b1; tick(); timerMatch = 1'b0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R11: reset state
    chk("R11", "dataOut", dataOut, 8'h00);
    chk("R11", "bufOut", bufOut, 8'h00);
    chk("R11", "serOut", {7'b0, serOut}, 8'h00);
    chk("R11", "ctrlRead", {5'b0, ctrlRead}, 8'h00);
    rstN = 1'b1;
    tick(2);

    // R1: select 00 without strobe ignores timer and external edges
    cpuWrite(8'h5A);
    setSel(2'b00, 1'b0);
    serIn = 1'b1;
    timerPulse();
    extClk = 1'b1; tick(5); extClk = 1'b0; tick(5);
    chk("R1", "idle word", dataOut, 8'h5A);

    // R2 R6 R1: strobe walk from the table
    cpuWrite(8'hA5);
    for (int i = 0; i < 8; i++) begin
      serIn = STROBE_VEC[i][8];
      tick(4);
      setSel(2'b00, 1'b1);
      chk("R2", "strobe word", dataOut, STROBE_VEC[i][7:0]);
      chk("R6", "transparent out", {7'b0, serOut}, {7'b0, STROBE_VEC[i][7]});
    end

    // R9: strobe reads zero
    chk("R9", "readback sel00", {5'b0, ctrlRead}, 8'h00);

    // R7: strobe uses bit from cycle before
    cpuWrite(8'h00);
    serIn = 1'b1; tick(5);
    ctrlWrEn = 1'b1; ctrlSel = 2'b00; ctrlStrobe = 1'b1; serIn = 1'b0;
    tick(); ctrlWrEn = 1'b0; ctrlStrobe = 1'b0;
    chk("R7", "prev-cycle bit", dataOut, 8'h01);
    tick(5);
    setSel(2'b00, 1'b1);
    chk("R7", "later bit", dataOut, 8'h02);

    // R8: write beats strobe
    cpuWrEn = 1'b1; cpuWrData = 8'h3C;
    ctrlWrEn = 1'b1; ctrlSel = 2'b00; ctrlStrobe = 1'b1;
    tick(); cpuWrEn = 1'b0; ctrlWrEn = 1'b0; ctrlStrobe = 1'b0;
    chk("R8", "write vs strobe", dataOut, 8'h3C);

    // R3: timer source
    setSel(2'b01, 1'b1);
    chk("R9", "readback sel01", {5'b0, ctrlRead}, 8'h02);
    chk("R1", "strobe with sel01", dataOut, 8'h3C);
    serIn = 1'b1; tick(4);
    cpuWrite(8'h00);
    timerPulse(); timerPulse(); timerPulse();
    chk("R3", "three timer shifts", dataOut, 8'h07);
    cpuWrEn = 1'b1; cpuWrData = 8'h55; timerMatch = 1'b1;
    tick(); cpuWrEn = 1'b0; timerMatch = 1'b0;
    chk("R8", "write vs timer", dataOut, 8'h55);
    timerMatch = 1'b1; tick(); timerMatch = 1'b0;
    chk("R3", "timer shift", dataOut, 8'hAB);
    chk("R6", "timer out", {7'b0, serOut}, 8'h01);

    // R4 R5: external rising sample, falling output
    cpuWrite(8'h00); tick(2);
    setSel(2'b10, 1'b0);
    cpuWrite(8'hC0);
    chk("R5", "latch holds before edge", {7'b0, serOut}, 8'h00);
    serIn = 1'b1; tick(4);
    extClk = 1'b1; tick(6);
    chk("R4", "rise shift", dataOut, 8'h81);
    chk("R5", "no out change on rise", {7'b0, serOut}, 8'h00);
    extClk = 1'b0; tick(6);
    chk("R5", "out on fall", {7'b0, serOut}, 8'h01);
    chk("R4", "no shift on fall", dataOut, 8'h81);

    // R4 R5: external falling sample, rising output
    setSel(2'b11, 1'b0);
    serIn = 1'b0; tick(4);
    extClk = 1'b1; tick(6);
    chk("R4", "no shift on rise", dataOut, 8'h81);
    chk("R5", "out on rise", {7'b0, serOut}, 8'h01);
    extClk = 1'b0; tick(6);
    chk("R4", "fall shift", dataOut, 8'h02);
    chk("R5", "hold on fall", {7'b0, serOut}, 8'h01);
    extClk = 1'b1; tick(6);
    chk("R5", "out on next rise", {7'b0, serOut}, 8'h00);

    // R10: buffer copy
    chk("R10", "buffer before pulse", bufOut, 8'h00);
    xferDone = 1'b1; tick(); xferDone = 1'b0;
    chk("R10", "buffer loaded", bufOut, 8'h02);
    cpuWrite(8'hE7); tick(2);
    chk("R10", "buffer holds", bufOut, 8'h02);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule